// File: doc/BRIEF.md
# USB Root Port Status Controller

This block keeps track of the single downstream port of a full/low-speed USB host. A device on this port is the only one directly attached; further devices are reached through hubs. The block senses attach and detach from a PHY abstraction, latches whether the attached device is low or full speed, and sequences bus reset, suspend and resume on software request. Three sticky change flags record connection changes, enable changes and port errors. Software clears them by writing ones, and they merge into one maskable port interrupt.

A port error is an over-current rising edge or a detach of an enabled port. It sets the error flag. Nothing else in the host is touched, so channel enables stay as they are and it is left to the host controller to choose a soft reset. Two sequencing rules are deliberate. A connection change seen while reset is driven is held back until reset ends. Re-resetting a port that is already enabled raises the enable-change flag both when reset starts and when it ends.

Top module: `usb_root_port`

## Requirements
- R1: `sts_connected` follows `phy_attached` one clock later, and each change of it outside reset sets change bit 0 (connect change) in the same cycle.
- R2: `ctl_reset` makes `bus_reset_drv` high from the next cycle for exactly `cfg_reset_len` cycles (a length of 0 acts as 1); a new request during reset restarts the count.
- R3: When reset ends with a device attached, `sts_enabled` becomes 1 and `sts_lowspeed` latches `phy_lowspeed` (1 = low speed, 0 = full speed).
- R4: Reset applied to an enabled port clears `sts_enabled` and sets change bit 1 (enable change) at reset start and sets it again at reset end; reset of a disabled port leaves bit 1 untouched.
- R5: A connect or disconnect seen while reset is driven does not set change bit 0 until the cycle reset ends.
- R6: A one in bit i of `chg_clr` clears change bit i; if a set event for the same bit falls in that cycle, the bit stays set.
- R7: `port_irq` is high exactly when some change bit is set whose `irq_mask` bit is 0.
- R8: A rising `phy_overcurrent`, or a detach while enabled, sets change bit 2 (port error) and clears `sts_enabled` without setting bit 1; `port_err` mirrors bit 2.
- R9: `ctl_suspend` on an enabled, idle port sets `sts_suspended` in the next cycle.
- R10: `ctl_resume` while suspended drops `sts_suspended` and drives `bus_resume_drv` for `cfg_resume_len` cycles (0 acts as 1), after which the port is idle and still enabled.
- R11: `ctl_suspend` on a disabled port is ignored: `sts_suspended` stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| phy_attached | input | 1 | Device pull-up sensed on the line |
| phy_lowspeed | input | 1 | Pull-up indicates a low-speed device |
| phy_overcurrent | input | 1 | Port power over-current flag |
| ctl_reset | input | 1 | Strobe: start bus reset |
| ctl_suspend | input | 1 | Strobe: suspend the port |
| ctl_resume | input | 1 | Strobe: resume a suspended port |
| chg_clr | input | 3 | Write-one-to-clear for change bits |
| irq_mask | input | 3 | Per change bit interrupt mask (1 = masked) |
| cfg_reset_len | input | CNT_W | Reset length in clock cycles |
| cfg_resume_len | input | CNT_W | Resume length in clock cycles |
| sts_connected | output | 1 | Device attached |
| sts_enabled | output | 1 | Port enabled |
| sts_lowspeed | output | 1 | Latched speed, 1 = low speed |
| sts_suspended | output | 1 | Port suspended |
| bus_reset_drv | output | 1 | Drive reset on the bus |
| bus_resume_drv | output | 1 | Drive resume on the bus |
| chg_bits | output | 3 | Sticky change bits: 0 connect, 1 enable, 2 error |
| port_irq | output | 1 | Port interrupt |
| port_err | output | 1 | Port error indication |

## Verification
Two pairs of functions can land on one clock edge. A software clear of a change bit can coincide with a fresh event that sets the same bit. The bench provokes this by attaching a device in the very cycle it clears the connect flag, and the flag is expected to survive. A detach can also coincide with a running reset. The bench removes the device in the middle of a re-reset and expects the connect flag to stay low through the remaining reset cycles and to appear together with the second enable change on the cycle reset ends.

// File: rtl/usb_port_pkg.sv
package usb_port_pkg;
  typedef enum logic [1:0] {
    PS_IDLE    = 2'd0,
    PS_RESET   = 2'd1,
    PS_SUSPEND = 2'd2,
    PS_RESUME  = 2'd3
  } port_state_e;

  localparam int NUM_CHG  = 3;
  localparam int CHG_CONN = 0;
  localparam int CHG_ENA  = 1;
  localparam int CHG_ERR  = 2;
endpackage

// File: rtl/port_line_sense.sv
module port_line_sense (
  input  logic clk,
  input  logic rst_n,
  input  logic phy_attached,
  input  logic phy_overcurrent,
  output logic conn_q,
  output logic attach_evt,
  output logic detach_evt,
  output logic oc_rise
);
  logic oc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      conn_q <= 1'b0;
      oc_q   <= 1'b0;
    end else begin
      conn_q <= phy_attached;
      oc_q   <= phy_overcurrent;
    end
  end

  assign attach_evt = phy_attached & ~conn_q;
  assign detach_evt = ~phy_attached & conn_q;
  assign oc_rise    = phy_overcurrent & ~oc_q;
endmodule

// File: rtl/port_bus_seq.sv
module port_bus_seq
  import usb_port_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctl_reset,
  input  logic             ctl_suspend,
  input  logic             ctl_resume,
  input  logic             enabled,
  input  logic             drop,
  input  logic [CNT_W-1:0] cfg_reset_len,
  input  logic [CNT_W-1:0] cfg_resume_len,
  output port_state_e      state,
  output logic             rst_start,
  output logic             rst_end
);
  port_state_e      state_n;
  logic [CNT_W-1:0] cnt_q, cnt_n;
  logic [CNT_W:0]   cnt_inc;
  logic [CNT_W:0]   len_sel;
  logic             cnt_last;

  assign cnt_inc  = {1'b0, cnt_q} + {{CNT_W{1'b0}}, 1'b1};
  assign len_sel  = (state == PS_RESET) ? {1'b0, cfg_reset_len} : {1'b0, cfg_resume_len};
  assign cnt_last = (cnt_inc >= len_sel);

  always_comb begin
    state_n = state;
    cnt_n   = cnt_q;
    if (ctl_reset) begin
      state_n = PS_RESET;
      cnt_n   = '0;
    end else begin
      case (state)
        PS_IDLE: begin
          if (ctl_suspend && enabled && !drop) state_n = PS_SUSPEND;
        end
        PS_RESET: begin
          if (cnt_last) begin
            state_n = PS_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
        PS_SUSPEND: begin
          if (drop) begin
            state_n = PS_IDLE;
          end else if (ctl_resume) begin
            state_n = PS_RESUME;
            cnt_n   = '0;
          end
        end
        default: begin
          if (drop || cnt_last) begin
            state_n = PS_IDLE;
            cnt_n   = '0;
          end else begin
            cnt_n = cnt_inc[CNT_W-1:0];
          end
        end
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= PS_IDLE;
      cnt_q <= '0;
    end else begin
      state <= state_n;
      cnt_q <= cnt_n;
    end
  end

  assign rst_start = ctl_reset;
  assign rst_end   = (state == PS_RESET) && cnt_last && !ctl_reset;

  p_reset_on_request_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_RESET) && ($past(state) != PS_RESET)) |-> $past(ctl_reset));

  p_suspend_needs_enable_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state == PS_SUSPEND) && ($past(state) == PS_IDLE)) |-> $past(enabled));
endmodule

// File: rtl/port_change_bank.sv
module port_change_bank #(
  parameter int N = 3
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] set,
  input  logic [N-1:0] clr,
  input  logic [N-1:0] mask,
  output logic [N-1:0] chg,
  output logic         irq
);
  for (genvar i = 0; i < N; i++) begin : g_bit
    logic bit_n;
    always_comb begin
      bit_n = chg[i];
      if (clr[i]) bit_n = 1'b0;
      if (set[i]) bit_n = 1'b1;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chg[i] <= 1'b0;
      else        chg[i] <= bit_n;
    end

    p_set_wins_r6: assert property (@(posedge clk) disable iff (!rst_n)
      set[i] |=> chg[i]);
    p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (clr[i] && !set[i]) |=> !chg[i]);
  end

  assign irq = |(chg & ~mask);
endmodule

// File: rtl/usb_root_port.sv
module usb_root_port
  import usb_port_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             phy_attached,
  input  logic             phy_lowspeed,
  input  logic             phy_overcurrent,
  input  logic             ctl_reset,
  input  logic             ctl_suspend,
  input  logic             ctl_resume,
  input  logic [2:0]       chg_clr,
  input  logic [2:0]       irq_mask,
  input  logic [CNT_W-1:0] cfg_reset_len,
  input  logic [CNT_W-1:0] cfg_resume_len,
  output logic             sts_connected,
  output logic             sts_enabled,
  output logic             sts_lowspeed,
  output logic             sts_suspended,
  output logic             bus_reset_drv,
  output logic             bus_resume_drv,
  output logic [2:0]       chg_bits,
  output logic             port_irq,
  output logic             port_err
);
  logic [1:0] rsync_q;
  logic       rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_ns = rsync_q[1];

  logic conn_q, attach_evt, detach_evt, oc_rise;
  port_state_e state;
  logic rst_start, rst_end, in_rst, conn_evt;
  logic en_q, en_n, ls_q, ls_n, pend_q, pend_n, rere_q, rere_n;
  logic [NUM_CHG-1:0] chg_set;

  port_line_sense u_sense (
    .clk             (clk),
    .rst_n           (rst_ns),
    .phy_attached    (phy_attached),
    .phy_overcurrent (phy_overcurrent),
    .conn_q          (conn_q),
    .attach_evt      (attach_evt),
    .detach_evt      (detach_evt),
    .oc_rise         (oc_rise)
  );

  port_bus_seq #(.CNT_W(CNT_W)) u_seq (
    .clk            (clk),
    .rst_n          (rst_ns),
    .ctl_reset      (ctl_reset),
    .ctl_suspend    (ctl_suspend),
    .ctl_resume     (ctl_resume),
    .enabled        (en_q),
    .drop           (detach_evt | oc_rise),
    .cfg_reset_len  (cfg_reset_len),
    .cfg_resume_len (cfg_resume_len),
    .state          (state),
    .rst_start      (rst_start),
    .rst_end        (rst_end)
  );

  assign in_rst   = (state == PS_RESET);
  assign conn_evt = attach_evt | detach_evt;

  always_comb begin
    en_n   = en_q;
    ls_n   = ls_q;
    rere_n = rere_q;
    pend_n = rst_end ? 1'b0 : (pend_q | (conn_evt & in_rst));
    if (rst_start) begin
      en_n   = 1'b0;
      rere_n = en_q | (in_rst & rere_q);
    end else if (rst_end) begin
      en_n   = conn_q & ~detach_evt;
      ls_n   = conn_q & ~detach_evt & phy_lowspeed;
      rere_n = 1'b0;
    end else begin
      if (detach_evt || oc_rise) en_n = 1'b0;
      if (detach_evt)            ls_n = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      en_q   <= 1'b0;
      ls_q   <= 1'b0;
      pend_q <= 1'b0;
      rere_q <= 1'b0;
    end else begin
      en_q   <= en_n;
      ls_q   <= ls_n;
      pend_q <= pend_n;
      rere_q <= rere_n;
    end
  end

  always_comb begin
    chg_set           = '0;
    chg_set[CHG_CONN] = (conn_evt & ~in_rst) | (rst_end & (pend_q | conn_evt));
    chg_set[CHG_ENA]  = (rst_start & en_q) | (rst_end & rere_q);
    chg_set[CHG_ERR]  = oc_rise | (detach_evt & en_q);
  end

  port_change_bank #(.N(NUM_CHG)) u_chg (
    .clk   (clk),
    .rst_n (rst_ns),
    .set   (chg_set),
    .clr   (chg_clr),
    .mask  (irq_mask),
    .chg   (chg_bits),
    .irq   (port_irq)
  );

  assign sts_connected  = conn_q;
  assign sts_enabled    = en_q;
  assign sts_lowspeed   = ls_q;
  assign sts_suspended  = (state == PS_SUSPEND);
  assign bus_reset_drv  = in_rst;
  assign bus_resume_drv = (state == PS_RESUME);
  assign port_err       = chg_bits[CHG_ERR];

  p_enable_after_reset_r3: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(en_q) |-> ($past(state) == PS_RESET));

  p_disabled_in_reset_r4: assert property (@(posedge clk) disable iff (!rst_ns)
    bus_reset_drv |-> !sts_enabled);

  p_conn_deferred_r5: assert property (@(posedge clk) disable iff (!rst_ns)
    (bus_reset_drv && $past(bus_reset_drv)) |-> !$rose(chg_bits[CHG_CONN]));

  p_err_disables_r8: assert property (@(posedge clk) disable iff (!rst_ns)
    $rose(chg_bits[CHG_ERR]) |-> !sts_enabled);
endmodule

// File: tb/usb_root_port_test.sv
`timescale 1ns/1ps
module usb_root_port_test;
  localparam int CNT_W = 16;
  localparam int F_CONN = 0, F_EN = 1, F_LS = 2, F_SUSP = 3, F_RST = 4;
  localparam int F_RES = 5, F_CHG = 6, F_IRQ = 7, F_ERR = 8;

  logic clk = 1'b0;
  logic rst_n;
  logic phy_attached, phy_lowspeed, phy_overcurrent;
  logic ctl_reset, ctl_suspend, ctl_resume;
  logic [2:0] chg_clr, irq_mask;
  logic [CNT_W-1:0] cfg_reset_len, cfg_resume_len;
  logic sts_connected, sts_enabled, sts_lowspeed, sts_suspended;
  logic bus_reset_drv, bus_resume_drv, port_irq, port_err;
  logic [2:0] chg_bits;

  always #2 clk = ~clk;

  usb_root_port #(.CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n),
    .phy_attached(phy_attached), .phy_lowspeed(phy_lowspeed),
    .phy_overcurrent(phy_overcurrent),
    .ctl_reset(ctl_reset), .ctl_suspend(ctl_suspend), .ctl_resume(ctl_resume),
    .chg_clr(chg_clr), .irq_mask(irq_mask),
    .cfg_reset_len(cfg_reset_len), .cfg_resume_len(cfg_resume_len),
    .sts_connected(sts_connected), .sts_enabled(sts_enabled),
    .sts_lowspeed(sts_lowspeed), .sts_suspended(sts_suspended),
    .bus_reset_drv(bus_reset_drv), .bus_resume_drv(bus_resume_drv),
    .chg_bits(chg_bits), .port_irq(port_irq), .port_err(port_err)
  );

  typedef struct {
    int         due;
    int         fld;
    logic [7:0] val;
    string      tag;
  } item_t;

  item_t sb[$];
  int cyc = 0;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  function automatic logic [7:0] probe(input int f);
    case (f)
      F_CONN:  return {7'd0, sts_connected};
      F_EN:    return {7'd0, sts_enabled};
      F_LS:    return {7'd0, sts_lowspeed};
      F_SUSP:  return {7'd0, sts_suspended};
      F_RST:   return {7'd0, bus_reset_drv};
      F_RES:   return {7'd0, bus_resume_drv};
      F_CHG:   return {5'd0, chg_bits};
      F_IRQ:   return {7'd0, port_irq};
      default: return {7'd0, port_err};
    endcase
  endfunction

  // monitor: compares queued expectations just after each rising edge
  initial begin
    forever begin
      @(posedge clk);
      cyc++;
      #1;
      while (sb.size() > 0 && sb[0].due <= cyc) begin
        item_t it;
        logic [7:0] got;
        it  = sb.pop_front();
        got = probe(it.fld);
        checks++;
        if (got !== it.val) begin
          errors++;
          $display("FAIL %s field %0d cycle %0d: got %0h expected %0h",
                   it.tag, it.fld, cyc, got, it.val);
        end
      end
    end
  end

  // driver side: expectation for the state after the next rising edge
  task automatic expect_next(input int f, input logic [7:0] v, input string tag);
    item_t it;
    it.due = cyc + 1;
    it.fld = f;
    it.val = v;
    it.tag = tag;
    sb.push_back(it);
  endtask

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic strobes_off();
    ctl_reset = 1'b0; ctl_suspend = 1'b0; ctl_resume = 1'b0; chg_clr = 3'b000;
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    phy_attached = 1'b0; phy_lowspeed = 1'b0; phy_overcurrent = 1'b0;
    strobes_off();
    irq_mask = 3'b000;
    cfg_reset_len = 16'd5;
    cfg_resume_len = 16'd3;
    repeat (3) tick();
    expect_next(F_CONN, 0, "reset R1");
    expect_next(F_EN, 0, "reset R3");
    expect_next(F_CHG, 0, "reset R6");
    expect_next(F_IRQ, 0, "reset R7");
    expect_next(F_RST, 0, "reset R2");
    tick();
    rst_n = 1'b1;
    repeat (3) tick();

    // R1 attach of a full-speed device
    phy_attached = 1'b1;
    expect_next(F_CONN, 1, "R1 attach");
    expect_next(F_CHG, 8'b001, "R1 connect change");
    expect_next(F_IRQ, 1, "R7 irq on change");
    tick();

    // R6 write-one-to-clear
    chg_clr = 3'b001;
    expect_next(F_CHG, 0, "R6 clear");
    expect_next(F_IRQ, 0, "R7 irq drops");
    tick();
    strobes_off();

    // R2 R3 first reset from a disabled port, R4 no enable change
    ctl_reset = 1'b1;
    expect_next(F_RST, 1, "R2 reset starts");
    expect_next(F_EN, 0, "R4 disabled during reset");
    tick();
    strobes_off();
    for (int k = 0; k < 4; k++) begin
      expect_next(F_RST, 1, "R2 reset held");
      tick();
    end
    expect_next(F_RST, 0, "R2 reset length");
    expect_next(F_EN, 1, "R3 enabled after reset");
    expect_next(F_LS, 0, "R3 full speed latched");
    expect_next(F_CHG, 0, "R4 no enable change from disabled");
    tick();

    // R9 suspend
    ctl_suspend = 1'b1;
    expect_next(F_SUSP, 1, "R9 suspend");
    tick();
    strobes_off();

    // R10 resume
    ctl_resume = 1'b1;
    expect_next(F_SUSP, 0, "R10 leave suspend");
    expect_next(F_RES, 1, "R10 resume drive");
    tick();
    strobes_off();
    for (int k = 0; k < 2; k++) begin
      expect_next(F_RES, 1, "R10 resume held");
      tick();
    end
    expect_next(F_RES, 0, "R10 resume length");
    expect_next(F_EN, 1, "R10 still enabled");
    tick();

    // R4 re-reset of an enabled port, low-speed device now
    phy_lowspeed = 1'b1;
    ctl_reset = 1'b1;
    expect_next(F_RST, 1, "R2 re-reset");
    expect_next(F_EN, 0, "R4 enable cleared");
    expect_next(F_CHG, 8'b010, "R4 enable change at start");
    expect_next(F_IRQ, 1, "R7 irq enable change");
    tick();
    strobes_off();
    chg_clr = 3'b010;
    expect_next(F_CHG, 0, "R6 clear enable change");
    expect_next(F_RST, 1, "R2 reset held");
    tick();
    strobes_off();
    for (int k = 0; k < 3; k++) begin
      expect_next(F_RST, 1, "R2 reset held");
      tick();
    end
    expect_next(F_RST, 0, "R2 re-reset length");
    expect_next(F_EN, 1, "R3 enabled again");
    expect_next(F_LS, 1, "R3 low speed latched");
    expect_next(F_CHG, 8'b010, "R4 enable change at end");
    tick();
    chg_clr = 3'b010;
    expect_next(F_CHG, 0, "R6 clear");
    tick();
    strobes_off();

    // R8 over-current
    phy_overcurrent = 1'b1;
    expect_next(F_CHG, 8'b100, "R8 error change only");
    expect_next(F_ERR, 1, "R8 port error");
    expect_next(F_EN, 0, "R8 disabled");
    expect_next(F_IRQ, 1, "R7 irq error");
    tick();
    irq_mask = 3'b100;
    expect_next(F_IRQ, 0, "R7 masked");
    expect_next(F_CHG, 8'b100, "R7 mask keeps bit");
    tick();
    irq_mask = 3'b000;
    chg_clr = 3'b100;
    expect_next(F_CHG, 0, "R6 clear error");
    expect_next(F_ERR, 0, "R8 error cleared");
    tick();
    strobes_off();

    // R11 suspend on a disabled port
    ctl_suspend = 1'b1;
    expect_next(F_SUSP, 0, "R11 suspend ignored");
    tick();
    strobes_off();
    expect_next(F_SUSP, 0, "R11 still not suspended");
    tick();

    // re-enable (from disabled)
    ctl_reset = 1'b1;
    tick();
    strobes_off();
    repeat (4) tick();
    expect_next(F_EN, 1, "R3 enabled");
    expect_next(F_CHG, 0, "R4 no change from disabled");
    tick();

    // R5 detach during a re-reset
    ctl_reset = 1'b1;
    expect_next(F_CHG, 8'b010, "R4 enable change at start");
    tick();
    strobes_off();
    phy_attached = 1'b0;
    expect_next(F_CONN, 0, "R1 detach seen");
    expect_next(F_CHG, 8'b010, "R5 connect change held back");
    tick();
    for (int k = 0; k < 3; k++) begin
      expect_next(F_CHG, 8'b010, "R5 still held back");
      tick();
    end
    expect_next(F_RST, 0, "R2 reset ends");
    expect_next(F_CHG, 8'b011, "R5 released with R4 end change");
    expect_next(F_EN, 0, "R3 no enable without device");
    expect_next(F_ERR, 0, "R8 no error in reset");
    tick();

    // R6 set wins over clear in the same cycle
    phy_attached = 1'b1;
    chg_clr = 3'b001;
    expect_next(F_CHG, 8'b011, "R6 set wins");
    expect_next(F_CONN, 1, "R1 attach");
    tick();
    strobes_off();
    chg_clr = 3'b011;
    expect_next(F_CHG, 0, "R6 clear both");
    tick();
    strobes_off();

    // R8 detach of an enabled port
    ctl_reset = 1'b1;
    tick();
    strobes_off();
    repeat (4) tick();
    expect_next(F_EN, 1, "R3 enabled");
    tick();
    phy_attached = 1'b0;
    expect_next(F_CONN, 0, "R1 detach");
    expect_next(F_EN, 0, "R8 disabled on detach");
    expect_next(F_CHG, 8'b101, "R8 error and connect change");
    expect_next(F_ERR, 1, "R8 port error");
    tick();

    repeat (3) tick();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule